// File: doc/BRIEF.md
# Interrupt Pin Request Dispatcher

This block sits between a set of interrupt request pins and the message fabric that carries interrupts to processors. Each pin takes its level from several independent sources, which are ORed together. A per-pin routing entry supplies the polarity, trigger type, mask, vector, destination, destination mode and delivery mode for that pin. The dispatcher tracks a pending bit for every pin and a remote-in-service bit for level-triggered pins. From these it decides whether a new assertion should produce an interrupt message or be folded into one that is already outstanding.

Messages leave one at a time. Each message is held steady until the fabric answers with accept or reject, and pins that are waiting are served lowest number first. End-of-interrupt broadcasts arrive tagged with a vector. Every routing entry that carries that vector raises an acknowledge pulse for its pin. A level-type broadcast also frees level-triggered pins, so that a pin whose line is still asserted is sent again. For each source command that leaves a pin asserted, the block tells the caller whether the assertion was taken for delivery or merged.

Top module: `irq_dispatch`

## Requirements
- R1: A pin's effective level is the OR of all its source bits, XORed with the pin's `cfg_pol` bit. A source command that leaves the effective level at 1 sets the pin's `pending` bit. One that leaves it at 0 clears the bit. Nothing else changes `pending`. `pending` is visible one clock after the command.
- R2: An edge-triggered pin (`cfg_trig` bit = 0) is taken for delivery only when the command moves its `pending` bit from 0 to 1. Any other command that leaves an edge pin asserted reports `rsp_merged` = 1.
- R3: A level-triggered pin (`cfg_trig` bit = 1) is taken for delivery only while its `remote_irr` bit is 0. While that bit is 1, an asserted command reports `rsp_merged` = 1.
- R4: No message is ever launched for a pin whose `cfg_mask` bit is 1 at launch time. Such a request is dropped. It still reports `rsp_merged` = 0.
- R5: When a level-triggered message is answered with `reply_ok` = 1, the pin's `remote_irr` bit is set. A rejected message leaves that bit at 0.
- R6: One clock after `eoi_valid`, `eoi_ack` carries a 1 for every pin whose 8-bit vector field equals `eoi_vec`. At all other times `eoi_ack` is zero.
- R7: A broadcast with `eoi_level` = 1 clears `remote_irr` on each matching level-triggered pin. If such a pin is unmasked and still pending, it is sent again. A broadcast with `eoi_level` = 0 leaves `remote_irr` unchanged.
- R8: A message copies the pin's vector, destination, destination mode and 3-bit delivery mode, carries the pin's trigger type, and has `msg_level` = 1. For pin 0 only, the message goes out with `msg_dmode` = 0 (physical) and `msg_dest` = `boot_id`.
- R9: When several pins wait, the lowest pin number launches first. A launched message keeps all of its fields stable until `reply_valid` arrives.
- R10: A clear-source command zeroes that source's bit on every pin. It does not change `pending`. Later commands on a pin see the cleared bit when the OR is formed.
- R11: After reset, `msg_valid`, `rsp_valid`, `eoi_ack`, `pending` and `remote_irr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_id | input | 8 | Destination forced onto pin-0 messages |
| cfg_mask | input | NPINS | Per-pin mask, 1 = blocked |
| cfg_trig | input | NPINS | Per-pin trigger type, 1 = level |
| cfg_pol | input | NPINS | Per-pin polarity, 1 = active low |
| cfg_dmode | input | NPINS | Per-pin destination mode |
| cfg_dlv | input | 3*NPINS | Per-pin delivery mode, pin p at [3p +: 3] |
| cfg_vec | input | 8*NPINS | Per-pin vector, pin p at [8p +: 8] |
| cfg_dest | input | 8*NPINS | Per-pin destination, pin p at [8p +: 8] |
| src_valid | input | 1 | Source level command |
| src_pin | input | log2(NPINS) | Pin addressed by the command |
| src_id | input | log2(NSRC) | Source addressed by the command |
| src_level | input | 1 | New level of that source bit |
| clr_valid | input | 1 | Clear-source command |
| clr_src | input | log2(NSRC) | Source to clear on every pin |
| eoi_valid | input | 1 | End-of-interrupt broadcast |
| eoi_vec | input | 8 | Vector being acknowledged |
| eoi_level | input | 1 | 1 = level-type broadcast |
| msg_valid | output | 1 | Message outstanding |
| msg_pin | output | log2(NPINS) | Pin the message belongs to |
| msg_dest | output | 8 | Message destination |
| msg_vec | output | 8 | Message vector |
| msg_dmode | output | 1 | Message destination mode |
| msg_dlv | output | 3 | Message delivery mode |
| msg_trig | output | 1 | Message trigger type |
| msg_level | output | 1 | Message level flag, always 1 |
| reply_valid | input | 1 | Fabric answer for the outstanding message |
| reply_ok | input | 1 | 1 = accepted, 0 = rejected |
| rsp_valid | output | 1 | Asserted-level command result is valid |
| rsp_merged | output | 1 | 1 = assertion merged, 0 = taken for delivery |
| eoi_ack | output | NPINS | Per-pin acknowledge pulse |
| pending | output | NPINS | Per-pin pending bits |
| remote_irr | output | NPINS | Per-pin remote-in-service bits |

## Verification
The assertions assume that in any clock at most one of `src_valid`, `clr_valid` and `eoi_valid` is high. They also assume that `reply_valid` appears only while `msg_valid` is high, that `boot_id` is steady, and that the routing entries do not change while a message is outstanding. The stimulus drives every command from a single task that raises exactly one strobe for one clock. Replies are issued only after the bench has seen `msg_valid`, and the routing configuration is written once before reset is released and never touched again.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DLV_W  = 3;

  // Input level as seen after the polarity inversion
  function automatic logic eff_level(input logic raw, input logic pol);
    return raw ^ pol;
  endfunction

  // Decide whether an asserted pin is taken for delivery
  function automatic logic wants_service(input logic eff, input logic was_pend,
                                         input logic lvl_trig, input logic rirr);
    if (!eff) return 1'b0;
    return lvl_trig ? !rirr : !was_pend;
  endfunction

  // Pin 0 is redirected to the boot processor
  function automatic logic [DEST_W-1:0] steer_dest(input logic is_pin0,
                                                   input logic [DEST_W-1:0] dest,
                                                   input logic [DEST_W-1:0] boot);
    return is_pin0 ? boot : dest;
  endfunction

  function automatic logic steer_dmode(input logic is_pin0, input logic dmode);
    return is_pin0 ? 1'b0 : dmode;
  endfunction
endpackage

// File: rtl/irqd_src_merge.sv
module irqd_src_merge #(
  parameter int NPINS = 8,
  parameter int NSRC  = 4,
  localparam int PW = $clog2(NPINS),
  localparam int SW = $clog2(NSRC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_valid,
  input  logic [PW-1:0] set_pin,
  input  logic [SW-1:0] set_src,
  input  logic          set_level,
  input  logic          clr_valid,
  input  logic [SW-1:0] clr_src,
  output logic          raw_next
);
  logic [NSRC-1:0] bits_q [NPINS];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      always_ff @(posedge clk) begin
        if (!rst_n)
          bits_q[p][s] <= 1'b0;
        else if (set_valid && set_pin == PW'(p) && set_src == SW'(s))
          bits_q[p][s] <= set_level;
        else if (clr_valid && clr_src == SW'(s))
          bits_q[p][s] <= 1'b0;
      end
    end
  end

  // OR of the addressed pin's sources with the incoming bit applied
  always_comb begin
    logic [NSRC-1:0] row;
    row = bits_q[set_pin];
    row[set_src] = set_level;
    raw_next = |row;
  end
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
  parameter int NPINS = 8,
  localparam int PW = $clog2(NPINS)
) (
  input  logic [NPINS-1:0] need,
  input  logic             enable,
  output logic             fire,
  output logic [PW-1:0]    fire_pin
);
  always_comb begin
    fire     = 1'b0;
    fire_pin = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (need[i]) begin
        fire     = enable;
        fire_pin = PW'(i);
      end
    end
  end
endmodule

// File: rtl/irqd_eoi_match.sv
module irqd_eoi_match import irqd_pkg::*; #(
  parameter int NPINS = 8
) (
  input  logic [NPINS*VEC_W-1:0] cfg_vec,
  input  logic [VEC_W-1:0]       eoi_vec,
  output logic [NPINS-1:0]       hit
);
  for (genvar p = 0; p < NPINS; p++) begin : g_cmp
    assign hit[p] = (cfg_vec[p*VEC_W +: VEC_W] == eoi_vec);
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch import irqd_pkg::*; #(
  parameter int NPINS = 8,
  parameter int NSRC  = 4,
  localparam int PW = $clog2(NPINS),
  localparam int SW = $clog2(NSRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DEST_W-1:0]       boot_id,
  input  logic [NPINS-1:0]        cfg_mask,
  input  logic [NPINS-1:0]        cfg_trig,
  input  logic [NPINS-1:0]        cfg_pol,
  input  logic [NPINS-1:0]        cfg_dmode,
  input  logic [NPINS*DLV_W-1:0]  cfg_dlv,
  input  logic [NPINS*VEC_W-1:0]  cfg_vec,
  input  logic [NPINS*DEST_W-1:0] cfg_dest,
  input  logic                    src_valid,
  input  logic [PW-1:0]           src_pin,
  input  logic [SW-1:0]           src_id,
  input  logic                    src_level,
  input  logic                    clr_valid,
  input  logic [SW-1:0]           clr_src,
  input  logic                    eoi_valid,
  input  logic [VEC_W-1:0]        eoi_vec,
  input  logic                    eoi_level,
  output logic                    msg_valid,
  output logic [PW-1:0]           msg_pin,
  output logic [DEST_W-1:0]       msg_dest,
  output logic [VEC_W-1:0]        msg_vec,
  output logic                    msg_dmode,
  output logic [DLV_W-1:0]        msg_dlv,
  output logic                    msg_trig,
  output logic                    msg_level,
  input  logic                    reply_valid,
  input  logic                    reply_ok,
  output logic                    rsp_valid,
  output logic                    rsp_merged,
  output logic [NPINS-1:0]        eoi_ack,
  output logic [NPINS-1:0]        pending,
  output logic [NPINS-1:0]        remote_irr
);
  logic [NPINS-1:0] pend_q, rirr_q, need_q;

  // Source merge: OR of per-source bits for the addressed pin
  logic raw_nx;
  irqd_src_merge #(.NPINS(NPINS), .NSRC(NSRC)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .set_valid(src_valid), .set_pin(src_pin), .set_src(src_id), .set_level(src_level),
    .clr_valid(clr_valid), .clr_src(clr_src),
    .raw_next(raw_nx)
  );

  // Named events for the checker
  logic eff_nx, svc_nx;
  assign eff_nx = eff_level(raw_nx, cfg_pol[src_pin]);
  assign svc_nx = wants_service(eff_nx, pend_q[src_pin], cfg_trig[src_pin], rirr_q[src_pin]);

  logic [NPINS-1:0] src_oh, svc_set;
  assign src_oh  = NPINS'(1) << src_pin;
  assign svc_set = (src_valid && svc_nx) ? src_oh : '0;

  // End-of-interrupt vector match
  logic [NPINS-1:0] vec_hit, rirr_drop, redo;
  irqd_eoi_match #(.NPINS(NPINS)) u_match (
    .cfg_vec(cfg_vec), .eoi_vec(eoi_vec), .hit(vec_hit)
  );
  assign rirr_drop = (eoi_valid && eoi_level) ? (vec_hit & cfg_trig) : '0;
  assign redo      = rirr_drop & ~cfg_mask & pend_q;

  // Lowest-first launch while no message is outstanding
  logic          fire, send;
  logic [PW-1:0] fire_pin;
  irqd_pick #(.NPINS(NPINS)) u_pick (
    .need(need_q), .enable(!msg_valid), .fire(fire), .fire_pin(fire_pin)
  );
  assign send = fire && !cfg_mask[fire_pin];

  logic [NPINS-1:0] fire_clr, acc_set;
  assign fire_clr = fire ? (NPINS'(1) << fire_pin) : '0;
  assign acc_set  = (msg_valid && reply_valid && reply_ok && msg_trig) ?
                    (NPINS'(1) << msg_pin) : '0;

  logic is_pin0;
  assign is_pin0 = (fire_pin == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      rirr_q     <= '0;
      need_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_merged <= 1'b0;
      eoi_ack    <= '0;
      msg_valid  <= 1'b0;
      msg_pin    <= '0;
      msg_dest   <= '0;
      msg_vec    <= '0;
      msg_dmode  <= 1'b0;
      msg_dlv    <= '0;
      msg_trig   <= 1'b0;
    end else begin
      if (src_valid) pend_q[src_pin] <= eff_nx;
      need_q     <= (need_q & ~fire_clr) | svc_set | redo;
      rirr_q     <= (rirr_q | acc_set) & ~rirr_drop;
      rsp_valid  <= src_valid && eff_nx;
      rsp_merged <= src_valid && eff_nx && !svc_nx;
      eoi_ack    <= eoi_valid ? vec_hit : '0;
      if (send) begin
        msg_valid <= 1'b1;
        msg_pin   <= fire_pin;
        msg_dest  <= steer_dest(is_pin0, cfg_dest[fire_pin*DEST_W +: DEST_W], boot_id);
        msg_vec   <= cfg_vec[fire_pin*VEC_W +: VEC_W];
        msg_dmode <= steer_dmode(is_pin0, cfg_dmode[fire_pin]);
        msg_dlv   <= cfg_dlv[fire_pin*DLV_W +: DLV_W];
        msg_trig  <= cfg_trig[fire_pin];
      end else if (reply_valid) begin
        msg_valid <= 1'b0;
      end
    end
  end

  assign msg_level  = 1'b1;
  assign pending    = pend_q;
  assign remote_irr = rirr_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk import irqd_pkg::*; #(
  parameter int NPINS = 8,
  localparam int PW = $clog2(NPINS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_valid,
  input logic [PW-1:0]     src_pin,
  input logic              eoi_valid,
  input logic [NPINS-1:0]  cfg_mask,
  input logic [NPINS-1:0]  cfg_trig,
  input logic [DEST_W-1:0] boot_id,
  input logic              msg_valid,
  input logic [PW-1:0]     msg_pin,
  input logic [VEC_W-1:0]  msg_vec,
  input logic [DEST_W-1:0] msg_dest,
  input logic              msg_dmode,
  input logic              msg_trig,
  input logic              reply_valid,
  input logic              reply_ok,
  input logic              rsp_valid,
  input logic              rsp_merged,
  input logic [NPINS-1:0]  eoi_ack,
  input logic [NPINS-1:0]  pending,
  input logic [NPINS-1:0]  remote_irr
);
  logic [NPINS-1:0] src_oh, msg_oh;
  assign src_oh = NPINS'(1) << src_pin;
  assign msg_oh = NPINS'(1) << msg_pin;

  AST_PEND_ONLY_BY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> $stable(pending)); // R1

  AST_EDGE_REPEAT_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && |(src_oh & ~cfg_trig & pending) |=> (!rsp_valid || rsp_merged)); // R2

  AST_LEVEL_BUSY_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid && |(src_oh & cfg_trig & remote_irr) |=> (!rsp_valid || rsp_merged)); // R3

  AST_MASKED_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> (!msg_valid || !(|(msg_oh & $past(cfg_mask))))); // R4

  AST_ACCEPT_SETS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && reply_valid && reply_ok && msg_trig && !eoi_valid
      |=> |(remote_irr & $past(msg_oh))); // R5

  AST_ACK_NEEDS_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_valid |=> (eoi_ack == '0)); // R6

  AST_PIN0_STEERED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_pin == '0 |-> (!msg_dmode && msg_dest == boot_id)); // R8

  AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !reply_valid |=> msg_valid && $stable(msg_pin) && $stable(msg_vec)
      && $stable(msg_dest)); // R9
endmodule

bind irq_dispatch irq_dispatch_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_pin(src_pin),
  .eoi_valid(eoi_valid), .cfg_mask(cfg_mask), .cfg_trig(cfg_trig), .boot_id(boot_id),
  .msg_valid(msg_valid), .msg_pin(msg_pin), .msg_vec(msg_vec), .msg_dest(msg_dest),
  .msg_dmode(msg_dmode), .msg_trig(msg_trig), .reply_valid(reply_valid),
  .reply_ok(reply_ok), .rsp_valid(rsp_valid), .rsp_merged(rsp_merged),
  .eoi_ack(eoi_ack), .pending(pending), .remote_irr(remote_irr)
);

// File: tb/irq_dispatch_bench.sv
`timescale 1ns/1ps
module irq_dispatch_bench;
  localparam int N = 8;
  localparam int S = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [7:0] boot_id;
  logic [N-1:0] cfg_mask, cfg_trig, cfg_pol, cfg_dmode;
  logic [N*3-1:0] cfg_dlv;
  logic [N*8-1:0] cfg_vec, cfg_dest;
  logic src_valid, src_level, clr_valid, eoi_valid, eoi_level, reply_valid, reply_ok;
  logic [2:0] src_pin;
  logic [1:0] src_id, clr_src;
  logic [7:0] eoi_vec;
  logic msg_valid, msg_dmode, msg_trig, msg_level, rsp_valid, rsp_merged;
  logic [2:0] msg_pin, msg_dlv;
  logic [7:0] msg_dest, msg_vec;
  logic [N-1:0] eoi_ack, pending, remote_irr;

  irq_dispatch #(.NPINS(N), .NSRC(S)) u_irq_dispatch (.*);

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic src_cmd(input int pin, input int src, input logic lvl);
    src_valid = 1'b1; src_pin = 3'(pin); src_id = 2'(src); src_level = lvl;
    tick();
    src_valid = 1'b0;
  endtask

  task automatic eoi_cmd(input logic [7:0] v, input logic lvl);
    eoi_valid = 1'b1; eoi_vec = v; eoi_level = lvl;
    tick();
    eoi_valid = 1'b0;
  endtask

  // Check the outstanding message against the routing rules, answer it,
  // then advance to where the next launch would be visible.
  task automatic take_msg(input int pin, input logic ok);
    logic [7:0] ev, ed;
    ev = (pin == 6) ? 8'h23 : 8'(8'h20 + pin);
    ed = (pin == 0) ? 8'h5A : 8'(8'h40 + pin);
    chk("R9 msg_valid", 32'(msg_valid), 1);
    chk("R9 msg_pin", 32'(msg_pin), 32'(pin));
    chk("R8 msg_vec", 32'(msg_vec), 32'(ev));
    chk("R8 msg_dest", 32'(msg_dest), 32'(ed));
    chk("R8 msg_dmode", 32'(msg_dmode), (pin == 0) ? 0 : 1);
    chk("R8 msg_dlv", 32'(msg_dlv), 32'(pin % 8));
    chk("R8 msg_trig", 32'(msg_trig), 32'(cfg_trig[pin]));
    chk("R8 msg_level", 32'(msg_level), 1);
    reply_valid = 1'b1; reply_ok = ok;
    tick();
    reply_valid = 1'b0; reply_ok = 1'b0;
    tick();
  endtask

  typedef struct packed {
    logic [2:0] pin;
    logic [1:0] src;
    logic       lvl;
    logic       rv;
    logic       mg;
    logic       pd;
  } row_t;

  // pin1 edge, pin2 edge active-low, pin3 level
  localparam row_t TBL [9] = '{
    '{3'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{3'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{3'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{3'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{3'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{3'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1},
    '{3'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; boot_id = 8'h5A;
    src_valid = 0; src_pin = 0; src_id = 0; src_level = 0;
    clr_valid = 0; clr_src = 0; eoi_valid = 0; eoi_vec = 0; eoi_level = 0;
    reply_valid = 0; reply_ok = 0;
    cfg_mask = 8'b0010_0000; cfg_trig = 8'b1100_1000;
    cfg_pol = 8'b0000_0100; cfg_dmode = '1;
    for (int p = 0; p < N; p++) begin
      cfg_vec[p*8 +: 8]  = (p == 6) ? 8'h23 : 8'(8'h20 + p);
      cfg_dest[p*8 +: 8] = 8'(8'h40 + p);
      cfg_dlv[p*3 +: 3]  = 3'(p);
    end
    tick(); tick();
    chk("R11 msg_valid", 32'(msg_valid), 0);
    chk("R11 rsp_valid", 32'(rsp_valid), 0);
    chk("R11 eoi_ack", 32'(eoi_ack), 0);
    chk("R11 pending", 32'(pending), 0);
    chk("R11 remote_irr", 32'(remote_irr), 0);
    rst_n = 1'b1;
    tick();

    // R1 R2 R3: level table walk
    for (int i = 0; i < 9; i++) begin
      src_cmd(int'(TBL[i].pin), int'(TBL[i].src), TBL[i].lvl);
      chk("R1 pending", 32'(pending[TBL[i].pin]), 32'(TBL[i].pd));
      chk("R2 rsp_valid", 32'(rsp_valid), 32'(TBL[i].rv));
      if (TBL[i].rv) chk("R2 rsp_merged", 32'(rsp_merged), 32'(TBL[i].mg));
    end

    // R9: held while unanswered, then lowest first
    chk("R9 held pin", 32'(msg_pin), 1);
    take_msg(1, 1'b1);
    take_msg(1, 1'b1);
    take_msg(2, 1'b1);
    take_msg(3, 1'b1);
    chk("R5 accept sets rirr", 32'(remote_irr[3]), 1);
    chk("R9 queue empty", 32'(msg_valid), 0);

    // R3: level pin in service merges
    src_cmd(3, 1, 1'b1);
    chk("R3 rsp_valid", 32'(rsp_valid), 1);
    chk("R3 rsp_merged", 32'(rsp_merged), 1);
    tick();
    chk("R3 no message", 32'(msg_valid), 0);

    // R6 R7: level broadcast on shared vector
    eoi_cmd(8'h23, 1'b1);
    chk("R6 eoi_ack", 32'(eoi_ack), 32'h48);
    chk("R7 rirr cleared", 32'(remote_irr[3]), 0);
    tick();
    chk("R6 ack one cycle", 32'(eoi_ack), 0);
    take_msg(3, 1'b1);
    chk("R7 only pending pin resent", 32'(msg_valid), 0);
    chk("R5 rirr set again", 32'(remote_irr[3]), 1);

    // R7: edge-type broadcast keeps rirr
    eoi_cmd(8'h23, 1'b0);
    chk("R6 eoi_ack edge", 32'(eoi_ack), 32'h48);
    chk("R7 rirr kept", 32'(remote_irr[3]), 1);
    tick();
    chk("R7 no resend", 32'(msg_valid), 0);

    // R8: pin 0 steered to boot processor
    src_cmd(0, 0, 1'b1);
    chk("R8 pin0 rsp", 32'(rsp_merged), 0);
    tick();
    take_msg(0, 1'b1);

    // R4: masked pin never sent
    src_cmd(5, 0, 1'b1);
    chk("R4 rsp_merged", 32'(rsp_merged), 0);
    chk("R4 pending", 32'(pending[5]), 1);
    tick(); tick(); tick();
    chk("R4 no message", 32'(msg_valid), 0);

    // R5: reject leaves rirr clear, so next assertion is taken
    src_cmd(7, 0, 1'b1);
    tick();
    take_msg(7, 1'b0);
    chk("R5 reject rirr", 32'(remote_irr[7]), 0);
    src_cmd(7, 1, 1'b1);
    chk("R5 retaken", 32'(rsp_merged), 0);
    tick();
    take_msg(7, 1'b1);
    chk("R5 accept rirr", 32'(remote_irr[7]), 1);

    // R10: clear source 1 everywhere
    clr_valid = 1'b1; clr_src = 2'd1;
    tick();
    clr_valid = 1'b0;
    chk("R10 pending kept", 32'(pending[1]), 1);
    src_cmd(1, 0, 1'b0);
    chk("R10 no rsp", 32'(rsp_valid), 0);
    chk("R10 pending dropped", 32'(pending[1]), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule